// File: doc/BRIEF.md
# Work RAM Refresh Arbiter

This block decides when the CPU work RAM is refreshed and holds back the CPU's data acknowledge when an access collides with a refresh. An interval counter advances on every CPU clock. After the counter passes a soft threshold, a refresh is pending. That refresh is issued at the moment the CPU begins its next work-RAM cycle, and that cycle then receives wait states. If the CPU does not touch work RAM before the counter reaches a hard threshold, the refresh is issued on its own and costs the CPU nothing.

A refresh holds the RAM for a fixed window of clocks. A work-RAM access whose address strobe falls inside a window that is already running waits only for the part of the window that remains. The outputs are an active-low refresh / output-enable strobe and a gate that allows the acknowledge for work-RAM cycles. The address decode and the real DRAM control lie outside the block.

Top module: `wram_refresh_arbiter`

## Requirements
- R1: After reset, `rfsh_n` is high, `dtack_ok` is low and the interval count is zero, so the first unprompted refresh starts on the 133rd clock edge after reset is released.
- R2: A work-RAM access begins on a clock edge where `as_n` is sampled low, `as_n` was high at the previous edge and `ram_sel` is high. Such a start triggers a refresh on that same edge only when the interval count is at least 116 (SOFT_TH) and no refresh is running. An access at a lower count triggers nothing.
- R3: The access that triggers a refresh gets exactly 3 (WIN-1) wait states: `dtack_ok` rises 3 clocks after the edge on which the access started.
- R4: With no work-RAM access, a refresh starts on the edge where the interval count is 132 (HARD_TH-1). Refreshes that occur only this way are 133 clocks apart.
- R5: On the edge that starts a refresh, `rfsh_n` goes low. It stays low for exactly 4 (WIN) clocks and then returns high.
- R6: A work-RAM access that starts 1, 2 or 3 clocks after a refresh start gets 2, 1 or 0 wait states. An access 3 or more clocks after the start gets none.
- R7: For a work-RAM access, `dtack_ok` is asserted after its wait states (on the start edge itself when there are none) and stays high while `as_n` stays low. It goes low on the first edge at which `as_n` is sampled high.
- R8: A strobe with `ram_sel` low neither starts a refresh nor raises `dtack_ok`, even when the interval count is past SOFT_TH.
- R9: The interval count returns to zero on the edge on which any refresh starts, whether an access or the timeout triggered it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | CPU address strobe, active low |
| ram_sel | input | 1 | High while the current address decodes to work RAM |
| rfsh_n | output | 1 | RAM refresh / output-enable strobe, active low, low for the refresh window |
| dtack_ok | output | 1 | High when the acknowledge for the current work-RAM cycle may be given |

## Verification
Every output is registered, so a refresh start shows on `rfsh_n` just after the edge that saw the access or the timeout count. `dtack_ok` rises a number of edges after the access start equal to the wait count, and it drops one edge after `as_n` rises. The bench drives its inputs on the falling edge. A reference model, stepped once per rising edge, predicts both outputs, and the bench compares them at the next falling edge, halfway between two active edges. The directed cases count these falling-edge samples, from the start of an access until `dtack_ok` rises and between falls of `rfsh_n`, so each interval is checked to the exact clock.

// File: rtl/wram_rfsh_pkg.sv
package wram_rfsh_pkg;

   // Wait states owed by an access that starts 'ofs' clocks after the refresh start,
   // for a refresh window of 'win' clocks (offset 0 is the start edge itself).
   function automatic int unsigned waits_for_offset(input int unsigned ofs,
                                                    input int unsigned win);
      if (ofs + 1 >= win) return 0;
      return win - 1 - ofs;
   endfunction

endpackage

// File: rtl/rfsh_interval_ctr.sv
module rfsh_interval_ctr #(
   parameter int unsigned SOFT_TH = 116,
   parameter int unsigned HARD_TH = 133,
   parameter int unsigned CNT_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             soft_due,
   output logic             hard_due
);
   localparam logic [CNT_W-1:0] SOFT_V = CNT_W'(SOFT_TH);
   localparam logic [CNT_W-1:0] HARD_V = CNT_W'(HARD_TH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (clr)         cnt_q <= '0;
      else if (!hard_due)   cnt_q <= cnt_q + 1'b1;
   end

   assign soft_due = (cnt_q >= SOFT_V);
   assign hard_due = (cnt_q == HARD_V);
endmodule

// File: rtl/rfsh_window.sv
module rfsh_window #(
   parameter int unsigned WIN  = 4,
   parameter int unsigned PH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            busy,
   output logic [PH_W-1:0] ph,
   output logic            rfsh_n
);
   localparam logic [PH_W-1:0] LAST = PH_W'(WIN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         ph     <= '0;
         rfsh_n <= 1'b1;
      end else if (start) begin
         busy   <= 1'b1;
         ph     <= '0;
         rfsh_n <= 1'b0;
      end else if (busy) begin
         if (ph == LAST) begin
            busy   <= 1'b0;
            ph     <= '0;
            rfsh_n <= 1'b1;
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rfsh_wait_gate.sv
module rfsh_wait_gate #(
   parameter int unsigned WT_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            as_n,
   input  logic            acc_start,
   input  logic [WT_W-1:0] waits,
   output logic            dtack_ok
);
   logic [WT_W-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt     <= '0;
         dtack_ok <= 1'b0;
      end else if (as_n) begin
         wcnt     <= '0;
         dtack_ok <= 1'b0;
      end else if (acc_start) begin
         wcnt     <= waits;
         dtack_ok <= (waits == '0);
      end else if (wcnt != '0) begin
         wcnt <= wcnt - 1'b1;
         if (wcnt == WT_W'(1)) dtack_ok <= 1'b1;
      end
   end
endmodule

// File: rtl/wram_refresh_arbiter.sv
module wram_refresh_arbiter #(
   parameter int unsigned SOFT_TH = 116,
   parameter int unsigned HARD_TH = 133,
   parameter int unsigned WIN     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   input  logic ram_sel,
   output logic rfsh_n,
   output logic dtack_ok
);
   import wram_rfsh_pkg::*;

   localparam int unsigned CNT_W = $clog2(HARD_TH);
   localparam int unsigned PH_W  = (WIN > 2) ? $clog2(WIN) : 1;
   localparam int unsigned WT_W  = (WIN > 2) ? $clog2(WIN) : 1;

   generate
      if (HARD_TH <= SOFT_TH) begin : g_bad_th
         $error("HARD_TH must exceed SOFT_TH");
      end
      if (SOFT_TH <= WIN) begin : g_bad_win
         $error("SOFT_TH must exceed the refresh window");
      end
      if (WIN < 2) begin : g_bad_len
         $error("refresh window must be at least 2 clocks");
      end
   endgenerate

   logic             as_prev;
   logic             acc_start;
   logic             rf_start;
   logic             soft_due, hard_due, busy;
   logic [CNT_W-1:0] cnt_q;
   logic [PH_W-1:0]  ph;
   logic [WT_W-1:0]  waits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) as_prev <= 1'b1;
      else        as_prev <= as_n;
   end

   assign acc_start = ram_sel && !as_n && as_prev;
   assign rf_start  = !busy && (hard_due || (soft_due && acc_start));

   always_comb begin
      waits = '0;
      if (acc_start) begin
         if (rf_start)  waits = WT_W'(waits_for_offset(0, WIN));
         else if (busy) waits = WT_W'(waits_for_offset(int'(ph) + 1, WIN));
      end
   end

   rfsh_interval_ctr #(.SOFT_TH(SOFT_TH), .HARD_TH(HARD_TH), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(rf_start),
      .cnt_q(cnt_q), .soft_due(soft_due), .hard_due(hard_due));

   rfsh_window #(.WIN(WIN), .PH_W(PH_W)) u_win (
      .clk(clk), .rst_n(rst_n), .start(rf_start),
      .busy(busy), .ph(ph), .rfsh_n(rfsh_n));

   rfsh_wait_gate #(.WT_W(WT_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .acc_start(acc_start),
      .waits(waits), .dtack_ok(dtack_ok));
endmodule

// File: rtl/wram_rfsh_checker.sv
module wram_rfsh_checker #(
   parameter int unsigned SOFT_TH = 116,
   parameter int unsigned HARD_TH = 133,
   parameter int unsigned CNT_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             as_n,
   input logic             ram_sel,
   input logic             rfsh_n,
   input logic             dtack_ok,
   input logic [CNT_W-1:0] cnt_q
);
   AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfsh_n) |-> ##1 !rfsh_n ##1 !rfsh_n ##1 !rfsh_n ##1 rfsh_n); // R5
   AST_HARD_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(HARD_TH - 1)) |=> $fell(rfsh_n)); // R4
   AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfsh_n) |-> (cnt_q == '0)); // R9
   AST_NO_EARLY_RFSH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfsh_n) |-> ($past(cnt_q) >= CNT_W'(SOFT_TH))); // R2
   AST_DTACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |=> !dtack_ok); // R7
   AST_NONRAM_NO_DTACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_sel && !as_n && $past(as_n)) |=> !dtack_ok); // R8
endmodule

bind wram_refresh_arbiter wram_rfsh_checker #(
   .SOFT_TH(SOFT_TH), .HARD_TH(HARD_TH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .as_n(as_n), .ram_sel(ram_sel),
   .rfsh_n(rfsh_n), .dtack_ok(dtack_ok), .cnt_q(cnt_q));

// File: tb/tb_wram_refresh_arbiter.sv
`timescale 1ns/1ps
module tb_wram_refresh_arbiter;
   localparam int SOFT = 116;
   localparam int HARD = 133;
   localparam int WINL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic as_n = 1'b1;
   logic ram_sel = 1'b0;
   logic rfsh_n, dtack_ok;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   int m_cnt = 0, m_ph = -1, m_wait = 0;
   bit m_prev = 1, m_dt = 0, m_rf_n = 1;
   // bench observation state
   bit prev_rf = 1, fell = 0;
   int since_fall = 0, low_len = 0, last_low = 0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   wram_refresh_arbiter #(.SOFT_TH(SOFT), .HARD_TH(HARD), .WIN(WINL)) dut (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .ram_sel(ram_sel),
      .rfsh_n(rfsh_n), .dtack_ok(dtack_ok));

   function automatic int exp_waits(input int ofs);
      return (ofs >= WINL - 1) ? 0 : WINL - 1 - ofs;
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit st_acc, st;
      int w;
      st_acc = !as_n && ram_sel && m_prev;
      st = (m_ph < 0) && (m_cnt == HARD - 1 || (m_cnt >= SOFT && st_acc));
      w = 0;
      if (st_acc) begin
         if (st) w = exp_waits(0);
         else if (m_ph >= 0) w = exp_waits(m_ph + 1);
      end
      if (as_n) begin m_dt = 0; m_wait = 0; end
      else if (st_acc) begin m_wait = w; m_dt = (w == 0); end
      else if (m_wait > 0) begin
         if (m_wait == 1) m_dt = 1;
         m_wait--;
      end
      if (st) begin m_ph = 0; m_rf_n = 0; end
      else if (m_ph >= 0) begin
         if (m_ph == WINL - 1) begin m_ph = -1; m_rf_n = 1; end
         else m_ph++;
      end
      m_cnt = st ? 0 : m_cnt + 1;
      m_prev = as_n;
   endtask

   task automatic cyc(input bit a, input bit s);
      as_n = a; ram_sel = s;
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag, rfsh_n, m_rf_n, "rfsh_n vs model");
      check(tag, dtack_ok, m_dt, "dtack_ok vs model");
      since_fall++;
      fell = prev_rf && !rfsh_n;
      if (fell) since_fall = 0;
      if (!rfsh_n) low_len++;
      else if (!prev_rf) begin last_low = low_len; low_len = 0; end
      prev_rf = rfsh_n;
   endtask

   // access held for 'hold' clocks; returns wait states seen and whether refresh started on it
   task automatic access(input bit s, input int hold, output int w, output bit rf_at_start);
      bit seen = 0;
      w = 0;
      for (int i = 0; i < hold; i++) begin
         cyc(1'b0, s);
         if (i == 0) rf_at_start = fell;
         if (dtack_ok) seen = 1;
         else if (!seen) w++;
      end
      cyc(1'b1, s);
   endtask

   task automatic wait_fall();
      do cyc(1'b1, 1'b0); while (!fell);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int w, gap;
      bit rfs;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check("R1", rfsh_n, 1, "rfsh_n in reset");
      check("R1", dtack_ok, 0, "dtack_ok in reset");
      rst_n = 1'b1;

      // R1/R4: first timeout refresh 133 clocks after reset, then 133 apart
      tag = "R4";
      gap = 0;
      do begin cyc(1'b1, 1'b0); gap++; end while (!fell);
      check("R1", gap, HARD, "first refresh after reset");
      gap = 0;
      do begin cyc(1'b1, 1'b0); gap++; end while (!fell);
      check("R4", gap, HARD, "timeout refresh spacing");
      check("R5", last_low, WINL, "refresh strobe width");

      // R2: early access, no refresh, no waits
      tag = "R2";
      while (since_fall < 50) cyc(1'b1, 1'b1);
      access(1'b1, 5, w, rfs);
      check("R2", rfs, 0, "no refresh below soft threshold");
      check("R2", w, 0, "no waits below soft threshold");

      // R2/R3/R9: soft-triggered refresh
      tag = "R3";
      while (since_fall < 120) cyc(1'b1, 1'b0);
      access(1'b1, 6, w, rfs);
      check("R2", rfs, 1, "refresh starts on access");
      check("R3", w, WINL - 1, "waits on triggering access");
      check("R5", last_low, WINL, "soft refresh strobe width");
      // R9: counter cleared at soft start -> next timeout 133 after that start
      gap = since_fall;
      do begin cyc(1'b1, 1'b0); gap++; end while (!fell);
      check("R9", gap, HARD, "count cleared on soft refresh");

      // R8: non-RAM strobe past soft threshold
      tag = "R8";
      while (since_fall < 118) cyc(1'b1, 1'b0);
      access(1'b0, 4, w, rfs);
      check("R8", rfs, 0, "non-RAM strobe starts no refresh");
      check("R8", dtack_ok, 0, "non-RAM dtack after strobe");
      check("R8", w, 4, "non-RAM never acknowledged");

      // R6: accesses inside a running window
      tag = "R6";
      for (int k = 1; k <= 4; k++) begin
         wait_fall();
         for (int j = 1; j < k; j++) cyc(1'b1, 1'b0);
         access(1'b1, 6, w, rfs);
         check("R6", w, exp_waits(k), $sformatf("waits at offset %0d", k));
      end

      // R7: release on strobe deassert
      tag = "R7";
      cyc(1'b0, 1'b1);
      check("R7", dtack_ok, 1, "dtack with no refresh pending");
      cyc(1'b0, 1'b1);
      check("R7", dtack_ok, 1, "dtack held while strobe low");
      cyc(1'b1, 1'b1);
      check("R7", dtack_ok, 0, "dtack released");

      // random mix, model-checked every clock
      tag = "R2 R3 R6 R7 R8";
      begin
         bit a = 1, s = 0;
         for (int i = 0; i < 6000; i++) begin
            if (a) begin
               if ($urandom_range(9) < 2) begin a = 0; s = ($urandom_range(3) != 0); end
            end else if ($urandom_range(3) == 0) a = 1;
            cyc(a, s);
         end
      end
      repeat (5) cyc(1'b1, 1'b0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule